// File: doc/BRIEF.md
# Charge-Pump Power-Up Sequencer with Latch-Off Protection

This block is the digital control for a two-rail charge-pump supply. It watches an active-high enable, a 1 MHz tick strobe, an over-current comparator and a comparator that reports when the positive rail is high enough. From these it drives five outputs:

- a pump-run signal;
- a start for the positive regulator;
- a start for the negative regulator;
- a flag showing that over-current is currently masked;
- a flag showing that the block has latched off.

All delays are counted in ticks. The tick counts are module parameters, so a simulation can shorten them.

The sequencer is a six-state machine. It holds the pump and both regulators off until the enable input has been seen low. After that, a rising enable moves the machine from IDLE to RAMP. In RAMP the pump runs. Once the startup delay has elapsed, the positive regulator is started and the machine enters WAIT_VH. When the rail monitor reports, the negative regulator is started and the machine enters RUN.

Over-current is ignored during a mask window that begins when startup begins. An over-current seen outside that window latches the block off in FAULT. The only way out of FAULT is to drive enable low and then high again.

When enable falls in RAMP, WAIT_VH or RUN, the machine enters STOPPING. There the pump keeps running for a fixed stop interval, and then the machine returns to IDLE. If enable rises during STOPPING, the stop interval still runs to its end before the block restarts.

Top module: `pump_seq_ctrl`

## Requirements
- R1: After reset all five outputs are low. If enable is high when reset releases, the block stays off until enable has been low for at least one clock and then goes high.
- R2: In IDLE, a high enable with the arm condition met moves the block to RAMP at the next clock, and pump_run goes high.
- R3: vh_reg_start goes high one clock after the START_TICKS-th tick counted in RAMP, and never earlier.
- R4: vl_reg_start is high only while vh_reg_start is high. It rises one clock after vh_good is seen high in WAIT_VH (transition WAIT_VH to RUN).
- R5: prot_mask is high in RAMP, WAIT_VH and RUN until MASK_TICKS ticks have been counted since RAMP was entered. While prot_mask is high, ocp_fault has no effect on any output.
- R6: An ocp_fault sampled high while unmasked in RAMP, WAIT_VH, RUN or STOPPING moves the block to FAULT at the next clock. In FAULT, pump_run, vh_reg_start and vl_reg_start are low and fault_latched is high. A fault takes priority over a falling enable in the same cycle.
- R7: FAULT is held for as long as enable stays high, whatever ticks arrive. A low enable moves the block from FAULT to IDLE, which clears fault_latched. The next rising enable starts a new ramp.
- R8: A low enable in RAMP, WAIT_VH or RUN moves the block to STOPPING. In STOPPING, pump_run stays high and both regulator starts are low. One clock after the STOP_TICKS-th tick counted in STOPPING, the block is in IDLE with pump_run low.
- R9: A rising enable during STOPPING does not shorten the stop interval. The block passes through IDLE for one clock with pump_run low, and then enters RAMP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock strobe once per microsecond |
| enable | input | 1 | Supply enable, active high |
| ocp_fault | input | 1 | Over-current comparator output, high on a short |
| vh_good | input | 1 | Positive-rail monitor, high once the rail crosses its threshold |
| pump_run | output | 1 | Charge-pump run request |
| vh_reg_start | output | 1 | Positive regulator start |
| vl_reg_start | output | 1 | Negative regulator start |
| prot_mask | output | 1 | High while over-current is being ignored |
| fault_latched | output | 1 | High while the block is latched off |

## Verification
The bench builds the block with START_TICKS = 5, MASK_TICKS = 9 and STOP_TICKS = 4. With these values every tick count of the startup, mask and stop windows can be stepped through one by one. The bench injects an over-current pulse after each tick count from 0 to MASK_TICKS + 2 and compares the latch-off decision with the arithmetic boundary. The same small counts keep short both the re-enable during STOPPING and the recovery from a reset taken with enable held high.

// File: rtl/pump_seq_pkg.sv
package pump_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RAMP,
        ST_WAIT_VH,
        ST_RUN,
        ST_STOPPING,
        ST_FAULT
    } seq_state_t;

endpackage

// File: rtl/seq_tick_timer.sv
// Saturating tick counter: counts strobes while not cleared, flags the limit.
module seq_tick_timer #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic expired
);
    localparam int W = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);

    logic [W-1:0] cnt_q;

    assign expired = (cnt_q == W'(LIMIT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (tick && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/seq_arm_latch.sv
// Start permission: set by any low enable, spent when a ramp begins.
module seq_arm_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic consume,
    output logic armed
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (!enable) begin
            armed <= 1'b1;
        end else if (consume) begin
            armed <= 1'b0;
        end
    end
endmodule

// File: rtl/pump_seq_ctrl.sv
module pump_seq_ctrl
    import pump_seq_pkg::*;
#(
    parameter int START_TICKS = 9400,
    parameter int MASK_TICKS  = 18000,
    parameter int STOP_TICKS  = 7500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic enable,
    input  logic ocp_fault,
    input  logic vh_good,
    output logic pump_run,
    output logic vh_reg_start,
    output logic vl_reg_start,
    output logic prot_mask,
    output logic fault_latched
);
    seq_state_t state_q, state_d;

    logic armed;
    logic start_done, mask_done, stop_done;
    logic in_startup;
    logic hit_fault;
    logic begin_ramp;

    assign in_startup = (state_q == ST_RAMP) || (state_q == ST_WAIT_VH) || (state_q == ST_RUN);
    assign begin_ramp = (state_q == ST_IDLE) && enable && armed;

    seq_arm_latch u_arm (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .consume (begin_ramp),
        .armed   (armed)
    );

    seq_tick_timer #(.LIMIT(START_TICKS)) u_start_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state_q != ST_RAMP),
        .tick    (tick),
        .expired (start_done)
    );

    seq_tick_timer #(.LIMIT(MASK_TICKS)) u_mask_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!in_startup),
        .tick    (tick),
        .expired (mask_done)
    );

    seq_tick_timer #(.LIMIT(STOP_TICKS)) u_stop_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state_q != ST_STOPPING),
        .tick    (tick),
        .expired (stop_done)
    );

    // Unmasked over-current: honoured in STOPPING, and in startup states once the mask ends.
    assign hit_fault = ocp_fault && ((in_startup && mask_done) || (state_q == ST_STOPPING));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (begin_ramp) state_d = ST_RAMP;
            end
            ST_RAMP: begin
                if (hit_fault)       state_d = ST_FAULT;
                else if (!enable)    state_d = ST_STOPPING;
                else if (start_done) state_d = ST_WAIT_VH;
            end
            ST_WAIT_VH: begin
                if (hit_fault)    state_d = ST_FAULT;
                else if (!enable) state_d = ST_STOPPING;
                else if (vh_good) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (hit_fault)    state_d = ST_FAULT;
                else if (!enable) state_d = ST_STOPPING;
            end
            ST_STOPPING: begin
                if (hit_fault)      state_d = ST_FAULT;
                else if (stop_done) state_d = ST_IDLE;
            end
            ST_FAULT: begin
                if (!enable) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pump_run      = 1'b0;
        vh_reg_start  = 1'b0;
        vl_reg_start  = 1'b0;
        fault_latched = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RAMP:     pump_run = 1'b1;
            ST_WAIT_VH: begin
                pump_run     = 1'b1;
                vh_reg_start = 1'b1;
            end
            ST_RUN: begin
                pump_run     = 1'b1;
                vh_reg_start = 1'b1;
                vl_reg_start = 1'b1;
            end
            ST_STOPPING: pump_run = 1'b1;
            ST_FAULT:    fault_latched = 1'b1;
            default: ;
        endcase
        prot_mask = in_startup && !mask_done;
    end
endmodule

// File: rtl/pump_seq_checker.sv
module pump_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic ocp_fault,
    input logic pump_run,
    input logic vh_reg_start,
    input logic vl_reg_start,
    input logic prot_mask,
    input logic fault_latched
);
    assert_fault_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fault_latched |-> (!pump_run && !vh_reg_start && !vl_reg_start));

    assert_vl_after_vh_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vl_reg_start |-> vh_reg_start);

    assert_fault_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_latched && enable) |=> fault_latched);

    assert_mask_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_mask && !fault_latched) |=> !fault_latched);

    assert_stop_keeps_pump_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && vh_reg_start && !ocp_fault) |=> (pump_run && !vh_reg_start));

    assert_vh_after_pump_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vh_reg_start) |-> $past(pump_run));
endmodule

bind pump_seq_ctrl pump_seq_checker i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .ocp_fault     (ocp_fault),
    .pump_run      (pump_run),
    .vh_reg_start  (vh_reg_start),
    .vl_reg_start  (vl_reg_start),
    .prot_mask     (prot_mask),
    .fault_latched (fault_latched)
);

// File: tb/test_pump_seq_ctrl.sv
module test_pump_seq_ctrl;
    localparam int START = 5;
    localparam int MASK  = 9;
    localparam int STOP  = 4;

    logic clk = 1'b0;
    logic rst_n, tick, enable, ocp_fault, vh_good;
    logic pump_run, vh_reg_start, vl_reg_start, prot_mask, fault_latched;
    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pump_seq_ctrl #(
        .START_TICKS (START),
        .MASK_TICKS  (MASK),
        .STOP_TICKS  (STOP)
    ) i_pump_seq_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .enable        (enable),
        .ocp_fault     (ocp_fault),
        .vh_good       (vh_good),
        .pump_run      (pump_run),
        .vh_reg_start  (vh_reg_start),
        .vl_reg_start  (vl_reg_start),
        .prot_mask     (prot_mask),
        .fault_latched (fault_latched)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic tk();
        tick = 1'b1;
        cyc();
        tick = 1'b0;
    endtask

    // Drop enable and let any stop interval run out (R8).
    task automatic go_idle();
        enable = 1'b0;
        for (int i = 0; i <= STOP; i++) begin
            tk();
            cyc();
        end
        check("R8 idle pump_run", pump_run, 1'b0);
        check("R8 idle fault_latched", fault_latched, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; tick = 1'b0; enable = 1'b0; ocp_fault = 1'b0; vh_good = 1'b0;
        cyc(); cyc();
        // R1 reset state
        check("R1 pump_run", pump_run, 1'b0);
        check("R1 vh_reg_start", vh_reg_start, 1'b0);
        check("R1 vl_reg_start", vl_reg_start, 1'b0);
        check("R1 prot_mask", prot_mask, 1'b0);
        check("R1 fault_latched", fault_latched, 1'b0);
        rst_n = 1'b1;
        cyc();

        // R2 start
        enable = 1'b1;
        cyc();
        check("R2 pump_run", pump_run, 1'b1);
        check("R5 mask at start", prot_mask, 1'b1);

        // R3/R5/R4 sweep across the startup and mask windows
        for (int n = 1; n <= MASK + 1; n++) begin
            tk();
            check("R5 prot_mask", prot_mask, (n < MASK));
            if (n == 2) begin
                ocp_fault = 1'b1;
                cyc();
                ocp_fault = 1'b0;
                check("R5 masked fault ignored", fault_latched, 1'b0);
                check("R5 masked fault pump", pump_run, 1'b1);
            end
            cyc();
            check("R3 vh_reg_start", vh_reg_start, (n >= START));
            check("R4 vl waits for vh_good", vl_reg_start, 1'b0);
        end
        vh_good = 1'b1;
        cyc();
        check("R4 vl_reg_start", vl_reg_start, 1'b1);

        // R6 unmasked fault in RUN
        ocp_fault = 1'b1;
        cyc();
        ocp_fault = 1'b0;
        check("R6 fault_latched", fault_latched, 1'b1);
        check("R6 pump_run", pump_run, 1'b0);
        check("R6 vh_reg_start", vh_reg_start, 1'b0);
        check("R6 vl_reg_start", vl_reg_start, 1'b0);

        // R7 held while enable high
        for (int i = 0; i < MASK + 2; i++) begin
            tk();
            check("R7 hold", fault_latched, 1'b1);
            check("R7 hold pump", pump_run, 1'b0);
        end
        enable = 1'b0;
        cyc();
        check("R7 clear on low", fault_latched, 1'b0);
        enable = 1'b1;
        cyc();
        check("R7 restart", pump_run, 1'b1);

        // R8 stop interval from RAMP, R9 re-enable inside it
        enable = 1'b0;
        cyc();
        check("R8 stopping pump", pump_run, 1'b1);
        for (int n = 1; n <= STOP; n++) begin
            if (n == 2) enable = 1'b1;
            tk();
            cyc();
            check("R9 stop not shortened", pump_run, (n < STOP));
            check("R8 vh off in stop", vh_reg_start, 1'b0);
        end
        cyc();
        check("R9 restart after idle", pump_run, 1'b1);
        check("R9 ramp vh low", vh_reg_start, 1'b0);

        // R8 stop from RUN with full tick sweep
        for (int n = 0; n < START; n++) tk();
        cyc(); cyc();
        check("R4 run vl", vl_reg_start, 1'b1);
        enable = 1'b0;
        cyc();
        check("R8 run to stopping pump", pump_run, 1'b1);
        check("R8 run to stopping vl", vl_reg_start, 1'b0);
        for (int n = 1; n <= STOP; n++) begin
            tk();
            cyc();
            check("R8 stop count", pump_run, (n < STOP));
        end

        // R6/R5 fault injection boundary sweep
        for (int n = 0; n <= MASK + 2; n++) begin
            go_idle();
            enable = 1'b1;
            cyc();
            for (int i = 0; i < n; i++) tk();
            ocp_fault = 1'b1;
            cyc();
            ocp_fault = 1'b0;
            check("R6 fault boundary", fault_latched, (n >= MASK));
            check("R6 pump boundary", pump_run, (n < MASK));
        end
        go_idle();

        // R1 reset with enable high must not start
        enable = 1'b1;
        rst_n = 1'b0;
        cyc();
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tk();
            check("R1 no start with enable high", pump_run, 1'b0);
        end
        enable = 1'b0;
        cyc();
        enable = 1'b1;
        cyc();
        check("R1 start after low", pump_run, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule